// File: doc/BRIEF.md
# Multiframe Phase Counter with SYSREF Offset Reload

This block keeps the local multiframe phase for one end of a converter link. It runs in the link clock domain and holds a free-running counter that steps through one multiframe, then wraps. A one-cycle tick marks each multiframe boundary, which is the point where the counter reads zero.

A rising edge on the SYSREF input re-phases the counter. The counter is not cleared to zero. It is loaded with a programmable phase value, which moves every later boundary. If the multiframe is L link clocks and the phase value is P, the next boundary arrives L-P cycles after the reload instead of at once. System software tunes P so that a synchronisation release is caught at a boundary that is both early and safe.

A mode input chooses when the counter re-phases. In one setting it locks on the first SYSREF edge after reset only. In the other it re-phases on every SYSREF edge.

Top module: `lmfc_phase_gen`

## Requirements
- R1: While rst_n is low, lmfc_cnt is 0 and lmfc_tick is 0. On the first cycle after reset is released, lmfc_cnt is still 0 and lmfc_tick is 1.
- R2: The multiframe length is L = mf_len_m1 + 1 link clocks. With no reload, lmfc_cnt steps by one each cycle from 0 to L-1, then returns to 0.
- R3: lmfc_tick is 1 exactly on the cycles where lmfc_cnt is 0. When L > 1 it is therefore high for one cycle in each multiframe.
- R4: Suppose sysref_in is sampled high at clock edge k after being sampled low at edge k-1. Then lmfc_cnt holds the reload value after edge k+2. The next tick follows L minus that value cycles later, or at once if the value is 0.
- R5: The reload value is phase_ofs modulo L. An offset of L or more is therefore reduced before it is loaded.
- R6: With realign_all = 1, every SYSREF rising edge reloads the counter. With realign_all = 0, only the first rising edge after reset reloads it, and later edges leave the count untouched.
- R7: A SYSREF edge whose reload value equals the count the counter would reach anyway leaves the count sequence and the tick spacing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sysref_in | input | 1 | SYSREF, already in the link clock domain |
| phase_ofs | input | CNT_W | Value loaded into the counter on reload |
| mf_len_m1 | input | CNT_W | Multiframe length minus one, in link clocks |
| realign_all | input | 1 | 1: re-phase on every SYSREF edge; 0: first edge only |
| lmfc_cnt | output | CNT_W | Current multiframe phase |
| lmfc_tick | output | 1 | Boundary tick, high while the phase is 0 |

## Verification
The hardest case to reach is a SYSREF edge that arrives exactly in phase with the running count. This needs the edge timed so that, two clocks later, the reload value matches the count the counter would reach on its own. It is the only case in which a reload must leave no trace at the ports. The bench reaches it by watching lmfc_cnt on the falling edge and raising sysref_in three sampled cycles before the counter would reach the programmed phase. It then follows the count and the tick across more than a full multiframe. A second SYSREF edge sent a few cycles after a boundary separates the two alignment modes, because only a re-phasing counter jumps to the offset there.

// File: rtl/lmfc_phase_gen.sv
`timescale 1ns/1ps
module lmfc_phase_gen #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sysref_in,
  input  logic [CNT_W-1:0] phase_ofs,
  input  logic [CNT_W-1:0] mf_len_m1,
  input  logic             realign_all,
  output logic [CNT_W-1:0] lmfc_cnt,
  output logic             lmfc_tick
);
  localparam int LEN_W = CNT_W + 1;
  localparam int REM_W = 2 * CNT_W + 1;

  logic [2:0]       sr_pipe;
  logic             run, locked;
  logic [CNT_W-1:0] cnt, ofs_mod;
  logic [LEN_W-1:0] len;
  logic             sr_rise, reload, at_end;

  assign len     = {1'b0, mf_len_m1} + LEN_W'(1);
  assign sr_rise = sr_pipe[1] & ~sr_pipe[2];
  assign reload  = sr_rise & (realign_all | ~locked);
  assign at_end  = (cnt >= mf_len_m1);

  always_comb begin
    logic [REM_W-1:0] rem, dv;
    rem = {{(CNT_W+1){1'b0}}, phase_ofs};
    dv  = '0;
    for (int i = CNT_W - 1; i >= 0; i--) begin
      dv = {{CNT_W{1'b0}}, len} << i;
      if (rem >= dv) rem = rem - dv;
    end
    ofs_mod = rem[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_pipe <= '0;
      run     <= 1'b0;
      locked  <= 1'b0;
      cnt     <= '0;
    end else begin
      sr_pipe <= {sr_pipe[1:0], sysref_in};
      run     <= 1'b1;
      if (reload) begin
        cnt    <= ofs_mod;
        locked <= 1'b1;
      end else if (run) begin
        cnt <= at_end ? '0 : cnt + CNT_W'(1);
      end
    end
  end

  assign lmfc_cnt  = cnt;
  assign lmfc_tick = run & (cnt == '0);

  a_r5_ofs_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    ofs_mod <= mf_len_m1);

  a_r4_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> lmfc_cnt == $past(ofs_mod));

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    run && !reload && cnt < mf_len_m1 |=> lmfc_cnt == $past(cnt) + CNT_W'(1));

  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    run && !reload && cnt == mf_len_m1 |=> lmfc_cnt == '0);

  a_r3_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
    lmfc_tick && !reload && mf_len_m1 != '0 && $stable(mf_len_m1) |=> !lmfc_tick);

  a_r6_lock_kept: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  a_r6_no_realign: assert property (@(posedge clk) disable iff (!rst_n)
    locked && !realign_all && run && cnt < mf_len_m1 |=> lmfc_cnt == $past(cnt) + CNT_W'(1));
endmodule

// File: tb/sim_lmfc_phase_gen.sv
`timescale 1ns/1ps
module sim_lmfc_phase_gen;
  localparam int W = 8;
  logic clk = 0, rst_n = 0, sysref = 0, mode = 0;
  logic [W-1:0] ofs = 0, lm1 = 7;
  logic [W-1:0] cnt;
  logic tick;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lmfc_phase_gen #(.CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .sysref_in(sysref), .phase_ofs(ofs),
    .mf_len_m1(lm1), .realign_all(mode), .lmfc_cnt(cnt), .lmfc_tick(tick));

  // {len_m1, offset, mode}
  localparam logic [16:0] VEC [8] = '{
    {8'd7,   8'd5,   1'b1},
    {8'd7,   8'd4,   1'b1},
    {8'd7,   8'd0,   1'b1},
    {8'd7,   8'd12,  1'b1},
    {8'd7,   8'd7,   1'b0},
    {8'd15,  8'd3,   1'b0},
    {8'd0,   8'd9,   1'b1},
    {8'd255, 8'd200, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; sysref = 0;
    step(3);
    rst_n = 1;
    step(1);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20ns * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      report();
    end
  end

  initial begin
    @(negedge clk);
    rst_n = 0; step(2);
    chk(cnt == 0, "R1 cnt in reset", cnt, 0);
    chk(tick == 0, "R1 tick in reset", tick, 0);
    rst_n = 1; step(1);
    chk(cnt == 0 && tick == 1, "R1 first cycle after reset", {cnt, tick}, 1);
    step(1);
    chk(cnt == 1 && tick == 0, "R2 count advances", cnt, 1);

    foreach (VEC[v]) begin
      int len, eload, d, esec;
      lm1 = VEC[v][16:9]; ofs = VEC[v][8:1]; mode = VEC[v][0];
      len = int'(lm1) + 1;
      eload = int'(ofs) % len;
      do_reset();
      step(3);
      sysref = 1;
      step(3);
      chk(int'(cnt) == eload, "R4 R5 reload value", cnt, eload);
      sysref = 0;
      d = 0;
      while (!tick && d < 300) begin step(1); d++; end
      chk(d == ((eload == 0) ? 0 : len - eload), "R4 boundary delay", d,
          (eload == 0) ? 0 : len - eload);
      step(1);
      chk(tick == (len == 1), "R3 tick width", tick, len == 1);
      step(1);
      sysref = 1;
      step(3);
      sysref = 0;
      esec = mode ? eload : (5 % len);
      chk(int'(cnt) == esec, "R6 second sysref", cnt, esec);
    end

    lm1 = 7; ofs = 3; mode = 1;
    do_reset();
    sysref = 1; step(3); sysref = 0;
    begin
      int g = 0;
      while (cnt != 0 && g < 50) begin step(1); g++; end
    end
    sysref = 1;
    for (int t = 1; t <= 12; t++) begin
      step(1);
      if (t == 2) sysref = 0;
      chk(int'(cnt) == t % 8, "R7 in-phase count", cnt, t % 8);
      chk(tick == (t % 8 == 0), "R7 in-phase tick", tick, t % 8 == 0);
    end

    done = 1;
    report();
  end
endmodule